// File: doc/BRIEF.md
# Graphics DRAM power-up sequencer for DLL-disabled operation

This block sits on the controller side of a graphics DDR DRAM interface. It takes the device from power-up into low-frequency operation with the delay-locked loop switched off. It owns the device reset, the clock enable, the four command strobes, the bank address and the row address. A one-cycle `start` pulse launches the series. The block then runs a stability wait measured in microseconds with the device held in reset and the clock enable low. Next it releases reset and holds the clock enable low for a fixed count of cycles. It then raises the clock enable and sends deselects for a further fixed count.

After that the block issues six commands, each followed by its own minimum gap. The six are: a precharge-all, an extended mode write that disables the DLL, a mode write that programs the read latency, a second precharge-all, and two auto-refreshes. When the gap after the second refresh has run out, `init_done` rises and stays high. From then on the rest of the controller may send any command. A synchronous reset returns the block to its idle state, which waits for `start`.

All timing values are parameters in clock cycles. The only exception is the stability wait, which is `STAB_US * CLK_MHZ` cycles. Elaboration rejects the following: a clock frequency outside 100 to 350 MHz, a read latency other than 7, 8 or 9, any command gap below 2, and an address bus narrower than 8 bits.

Top module: `dlloff_power_up_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the outputs are `dram_rst_n`=0, `dram_cke`=0, `dram_cmd`=4'b1111, `dram_ba`=0, `dram_addr`=0 and `init_done`=0. They keep these values until `start` is sampled high.
- R2: In the cycle after `start` is sampled high in idle, a stability wait of `STAB_US*CLK_MHZ` cycles begins. During the wait, `dram_rst_n` and `dram_cke` stay low and the command is deselect.
- R3: After the stability wait, `dram_rst_n` goes high while `dram_cke` stays low for `HOLD_RST` cycles. Then `dram_cke` goes high and the command stays deselect for `HOLD_CKE` cycles. No non-deselect command is issued unless both `dram_rst_n` and `dram_cke` are high.
- R4: `dram_cmd` is packed as {cs_n, ras_n, cas_n, we_n}. The encodings are deselect 4'b1111, precharge-all 4'b0010, mode write 4'b0000 and auto-refresh 4'b0001. The six command cycles come in this order: precharge-all, extended mode write, mode write, precharge-all, auto-refresh, auto-refresh.
- R5: The extended mode write drives `dram_ba`=2'b01 and `dram_addr`=1, so that bit 0 is high and the DLL is disabled.
- R6: The mode write drives `dram_ba`=2'b00, `dram_addr[7:4]`=`RD_LAT` and all other address bits 0.
- R7: Each command lasts one cycle. The next command follows after `T_RP` cycles for a precharge-all, `T_MRD` cycles for either mode write, and `T_RFC` cycles for an auto-refresh.
- R8: In every cycle that is not a command slot, `dram_cmd` is 4'b1111 and `dram_ba` and `dram_addr` are zero.
- R9: `init_done` rises exactly `T_RFC` cycles after the second auto-refresh and stays high until `rst`. A `start` pulse seen anywhere other than idle has no effect.
- R10: If `rst` is asserted at any point in the series, the outputs return to the R1 values in the next cycle, and a later `start` runs the full series again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the power-up series from idle |
| dram_rst_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| dram_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| dram_ba | output | 2 | Bank address |
| dram_addr | output | ADDR_W | Row address / mode word |
| init_done | output | 1 | Series complete, normal traffic allowed |

## Verification
The outputs are decoded directly from the phase, step index and command-flag registers. A wrong phase therefore shows up on `dram_rst_n`, `dram_cke` or `dram_cmd` in the same cycle. A step index that is off by one gives a wrong command or mode word at the next command slot, which comes at most `T_RFC` cycles later. A timer that loads the wrong value shifts every later command and the rise of `init_done`. The bench compares all outputs in every cycle against a timeline computed from cycles counted since `start`, so such a shift is caught at its first misplaced edge.

// File: rtl/dps_pkg.sv
package dps_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS  = 4'b0000,
      CMD_ARF  = 4'b0001,
      CMD_PREA = 4'b0010,
      CMD_DES  = 4'b1111
   } dram_cmd_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_STAB,
      PH_RSTH,
      PH_CKEH,
      PH_CMD,
      PH_DONE
   } phase_e;

   typedef enum logic [1:0] {
      AK_ZERO,
      AK_EXT,
      AK_BASE
   } addr_kind_e;

   typedef struct packed {
      dram_cmd_e  cmd;
      logic [1:0] ba;
      addr_kind_e kind;
   } step_t;

   localparam int unsigned NUM_STEPS = 6;
   localparam int unsigned RL_LSB    = 4;
   localparam int unsigned RL_W      = 4;

endpackage

// File: rtl/dps_gap_timer.sv
module dps_gap_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/dps_step_table.sv
module dps_step_table import dps_pkg::*; #(
   parameter int unsigned T_RP  = 4,
   parameter int unsigned T_MRD = 6,
   parameter int unsigned T_RFC = 40,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned CNT_W = 16
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step,
   output logic [CNT_W-1:0] gap_m1
);

   localparam logic [CNT_W-1:0] RP_M1  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] MRD_M1 = CNT_W'(T_MRD - 1);
   localparam logic [CNT_W-1:0] RFC_M1 = CNT_W'(T_RFC - 1);

   always_comb begin
      step   = '{cmd: CMD_DES, ba: 2'b00, kind: AK_ZERO};
      gap_m1 = RFC_M1;
      case (idx)
         IDX_W'(0): begin step = '{cmd: CMD_PREA, ba: 2'b00, kind: AK_ZERO}; gap_m1 = RP_M1;  end
         IDX_W'(1): begin step = '{cmd: CMD_MRS,  ba: 2'b01, kind: AK_EXT};  gap_m1 = MRD_M1; end
         IDX_W'(2): begin step = '{cmd: CMD_MRS,  ba: 2'b00, kind: AK_BASE}; gap_m1 = MRD_M1; end
         IDX_W'(3): begin step = '{cmd: CMD_PREA, ba: 2'b00, kind: AK_ZERO}; gap_m1 = RP_M1;  end
         IDX_W'(4): begin step = '{cmd: CMD_ARF,  ba: 2'b00, kind: AK_ZERO}; gap_m1 = RFC_M1; end
         IDX_W'(5): begin step = '{cmd: CMD_ARF,  ba: 2'b00, kind: AK_ZERO}; gap_m1 = RFC_M1; end
         default:   begin step = '{cmd: CMD_DES,  ba: 2'b00, kind: AK_ZERO}; gap_m1 = RFC_M1; end
      endcase
   end

endmodule

// File: rtl/dps_mode_word.sv
module dps_mode_word import dps_pkg::*; #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned RD_LAT = 8
) (
   input  logic              issue,
   input  addr_kind_e        kind,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned LOW_W = RL_LSB + RL_W;

   logic [LOW_W-1:0] low_word;

   always_comb begin
      low_word = '0;
      if (issue) begin
         case (kind)
            AK_EXT:  low_word[0] = 1'b1;
            AK_BASE: low_word[RL_LSB +: RL_W] = RL_W'(RD_LAT);
            default: low_word = '0;
         endcase
      end
   end

   generate
      if (ADDR_W > LOW_W) begin : g_wide
         assign addr = {{(ADDR_W-LOW_W){1'b0}}, low_word};
      end else begin : g_exact
         assign addr = low_word[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dlloff_power_up_seq.sv
module dlloff_power_up_seq import dps_pkg::*; #(
   parameter int unsigned CLK_MHZ  = 250,
   parameter int unsigned STAB_US  = 200,
   parameter int unsigned HOLD_RST = 300,
   parameter int unsigned HOLD_CKE = 700,
   parameter int unsigned T_RP     = 4,
   parameter int unsigned T_MRD    = 6,
   parameter int unsigned T_RFC    = 40,
   parameter int unsigned RD_LAT   = 8,
   parameter int unsigned ADDR_W   = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              dram_rst_n,
   output logic              dram_cke,
   output logic [3:0]        dram_cmd,
   output logic [1:0]        dram_ba,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              init_done
);

   localparam int unsigned STAB_CYC = STAB_US * CLK_MHZ;
   localparam int unsigned SPAN_A   = (STAB_CYC > HOLD_RST) ? STAB_CYC : HOLD_RST;
   localparam int unsigned SPAN_B   = (HOLD_CKE > T_RFC) ? HOLD_CKE : T_RFC;
   localparam int unsigned SPAN_C   = (T_RP > T_MRD) ? T_RP : T_MRD;
   localparam int unsigned SPAN_AB  = (SPAN_A > SPAN_B) ? SPAN_A : SPAN_B;
   localparam int unsigned MAX_SPAN = (SPAN_AB > SPAN_C) ? SPAN_AB : SPAN_C;
   localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);
   localparam int unsigned IDX_W    = $clog2(NUM_STEPS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

   // elaboration-time parameter checks
   generate
      if (CLK_MHZ < 100 || CLK_MHZ > 350) begin : g_bad_clk
         $error("CLK_MHZ must lie in 100..350 for DLL-disabled operation");
      end
      if (RD_LAT < 7 || RD_LAT > 9) begin : g_bad_rl
         $error("RD_LAT must be 7, 8 or 9 with the DLL disabled");
      end
      if (T_RP < 2 || T_MRD < 2 || T_RFC < 2) begin : g_bad_gap
         $error("command gaps must be at least 2 cycles");
      end
      if (STAB_US < 1 || HOLD_RST < 1 || HOLD_CKE < 1) begin : g_bad_hold
         $error("wait phases must be at least one cycle");
      end
      if (ADDR_W < RL_LSB + RL_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the mode word");
      end
   endgenerate

   phase_e           phase_q, phase_d;
   logic [IDX_W-1:0] idx_q, idx_d, idx_nxt;
   logic             issue_q, issue_d;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   step_t            cur_step, nxt_step;
   logic [CNT_W-1:0] cur_gap_m1, nxt_gap_m1;
   logic             slot_live;

   dps_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   dps_step_table #(
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_cur_step (
      .idx    (idx_q),
      .step   (cur_step),
      .gap_m1 (cur_gap_m1)
   );

   assign idx_nxt = (phase_q == PH_CKEH) ? '0 : idx_q + 1'b1;

   dps_step_table #(
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_nxt_step (
      .idx    (idx_nxt),
      .step   (nxt_step),
      .gap_m1 (nxt_gap_m1)
   );

   always_comb begin
      phase_d  = phase_q;
      idx_d    = idx_q;
      issue_d  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (phase_q)
         PH_IDLE: if (start) begin
            phase_d  = PH_STAB;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(STAB_CYC - 1);
         end
         PH_STAB: if (tmr_expired) begin
            phase_d  = PH_RSTH;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HOLD_RST - 1);
         end
         PH_RSTH: if (tmr_expired) begin
            phase_d  = PH_CKEH;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HOLD_CKE - 1);
         end
         PH_CKEH: if (tmr_expired) begin
            phase_d  = PH_CMD;
            idx_d    = idx_nxt;
            issue_d  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = nxt_gap_m1;
         end
         PH_CMD: if (tmr_expired) begin
            if (idx_q == LAST_IDX) begin
               phase_d = PH_DONE;
            end else begin
               idx_d    = idx_nxt;
               issue_d  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = nxt_gap_m1;
            end
         end
         default: phase_d = phase_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         issue_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         idx_q   <= idx_d;
         issue_q <= issue_d;
      end
   end

   assign slot_live  = (phase_q == PH_CMD) && issue_q;
   assign dram_rst_n = (phase_q != PH_IDLE) && (phase_q != PH_STAB);
   assign dram_cke   = (phase_q == PH_CKEH) || (phase_q == PH_CMD) || (phase_q == PH_DONE);
   assign init_done  = (phase_q == PH_DONE);
   assign dram_cmd   = slot_live ? cur_step.cmd : CMD_DES;
   assign dram_ba    = slot_live ? cur_step.ba : 2'b00;

   dps_mode_word #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_mode_word (
      .issue (slot_live),
      .kind  (cur_step.kind),
      .addr  (dram_addr)
   );

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned RD_LAT = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              dram_rst_n,
   input logic              dram_cke,
   input logic [3:0]        dram_cmd,
   input logic [1:0]        dram_ba,
   input logic [ADDR_W-1:0] dram_addr,
   input logic              init_done
);

   AST_RESET_TO_IDLE: assert property (@(posedge clk) rst |=> (!dram_rst_n && !dram_cke && !init_done && dram_cmd == 4'b1111)); // R10
   AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst) (dram_cmd != 4'b1111) |-> (dram_cke && dram_rst_n)); // R3
   AST_CKE_AFTER_RST: assert property (@(posedge clk) disable iff (rst) dram_cke |-> dram_rst_n); // R3
   AST_EXT_DLL_OFF: assert property (@(posedge clk) disable iff (rst) (dram_cmd == 4'b0000 && dram_ba == 2'b01) |-> (dram_addr == ADDR_W'(1))); // R5
   AST_BASE_RL: assert property (@(posedge clk) disable iff (rst) (dram_cmd == 4'b0000 && dram_ba == 2'b00) |-> (dram_addr[7:4] == 4'(RD_LAT))); // R6
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) (dram_cmd != 4'b1111) |=> (dram_cmd == 4'b1111)); // R7
   AST_DES_QUIET: assert property (@(posedge clk) disable iff (rst) (dram_cmd == 4'b1111) |-> (dram_addr == '0 && dram_ba == 2'b00)); // R8
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) init_done |-> (dram_cmd == 4'b1111 && dram_cke)); // R9

endmodule

bind dlloff_power_up_seq dps_checker #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_dps_checker (
   .clk        (clk),
   .rst        (rst),
   .dram_rst_n (dram_rst_n),
   .dram_cke   (dram_cke),
   .dram_cmd   (dram_cmd),
   .dram_ba    (dram_ba),
   .dram_addr  (dram_addr),
   .init_done  (init_done)
);

// File: tb/dlloff_power_up_seq_bench.sv
`timescale 1ns/1ps
module dlloff_power_up_seq_bench;

   localparam int CLK_MHZ  = 100;
   localparam int STAB_US  = 1;
   localparam int HOLD_RST = 300;
   localparam int HOLD_CKE = 700;
   localparam int T_RP     = 3;
   localparam int T_MRD    = 4;
   localparam int T_RFC    = 9;
   localparam int RD_LAT   = 8;
   localparam int ADDR_W   = 13;
   localparam int S_CYC    = STAB_US * CLK_MHZ;
   localparam int CMD_BASE = S_CYC + HOLD_RST + HOLD_CKE;
   localparam int SEQ_LEN  = 2 * T_RP + 2 * T_MRD + 2 * T_RFC;
   localparam int TOTAL    = CMD_BASE + SEQ_LEN;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic              dram_rst_n, dram_cke, init_done;
   logic [3:0]        dram_cmd;
   logic [1:0]        dram_ba;
   logic [ADDR_W-1:0] dram_addr;

   dlloff_power_up_seq #(
      .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .HOLD_RST(HOLD_RST), .HOLD_CKE(HOLD_CKE),
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .RD_LAT(RD_LAT), .ADDR_W(ADDR_W)
   ) u_dlloff_power_up_seq (
      .clk(clk), .rst(rst), .start(start),
      .dram_rst_n(dram_rst_n), .dram_cke(dram_cke), .dram_cmd(dram_cmd),
      .dram_ba(dram_ba), .dram_addr(dram_addr), .init_done(init_done)
   );

   int  checks = 0;
   int  errors = 0;
   int  cycles = 0;
   bit  armed = 0;
   bit  running = 0;
   int  t = 0;
   bit  post_rst = 0;
   bit  mid = 0;
   bit  finished = 0;

   // reference timeline, driven only by the bench's own inputs
   always @(posedge clk) begin
      armed    <= 1'b1;
      post_rst <= rst;
      cycles   <= cycles + 1;
      if (rst) begin
         running <= 1'b0;
         t       <= 0;
      end else if (!running) begin
         if (start) begin
            running <= 1'b1;
            t       <= 0;
         end
      end else if (t < 1000000) begin
         t <= t + 1;
      end
   end

   function automatic int gap_of(input int i);
      if (i == 0 || i == 3) return T_RP;
      if (i == 1 || i == 2) return T_MRD;
      return T_RFC;
   endfunction

   function automatic void expect_at(input bit run, input int tt,
                                     output bit e_rn, output bit e_cke, output logic [3:0] e_cmd,
                                     output logic [1:0] e_ba, output logic [ADDR_W-1:0] e_addr,
                                     output bit e_done, output string tag);
      int off;
      int rel;
      e_rn = 0; e_cke = 0; e_cmd = 4'b1111; e_ba = 2'b00; e_addr = '0; e_done = 0; tag = "R1";
      if (!run) return;
      if (tt < S_CYC) begin tag = "R2"; return; end
      e_rn = 1;
      if (tt < S_CYC + HOLD_RST) begin tag = "R3"; return; end
      e_cke = 1;
      if (tt < CMD_BASE) begin tag = "R3"; return; end
      rel = tt - CMD_BASE;
      tag = "R8";
      off = 0;
      for (int i = 0; i < 6; i++) begin
         if (rel == off) begin
            case (i)
               0, 3: begin e_cmd = 4'b0010; tag = "R4"; end
               1:    begin e_cmd = 4'b0000; e_ba = 2'b01; e_addr = ADDR_W'(1); tag = "R5"; end
               2:    begin e_cmd = 4'b0000; e_addr = ADDR_W'(RD_LAT << 4); tag = "R6"; end
               default: begin e_cmd = 4'b0001; tag = "R7"; end
            endcase
         end
         off += gap_of(i);
      end
      if (rel >= off) begin e_done = 1; tag = "R9"; end
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, what, t, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit e_rn, e_cke, e_done;
      logic [3:0] e_cmd;
      logic [1:0] e_ba;
      logic [ADDR_W-1:0] e_addr;
      string tag;
      if (armed && !finished) begin
         expect_at(running, t, e_rn, e_cke, e_cmd, e_ba, e_addr, e_done, tag);
         if (post_rst) tag = mid ? "R10" : "R1";
         chk(tag, "dram_rst_n", int'(dram_rst_n), int'(e_rn));
         chk(tag, "dram_cke",   int'(dram_cke),   int'(e_cke));
         chk(tag, "dram_cmd",   int'(dram_cmd),   int'(e_cmd));
         chk(tag, "dram_ba",    int'(dram_ba),    int'(e_ba));
         chk(tag, "dram_addr",  int'(dram_addr),  int'(e_addr));
         chk(tag, "init_done",  int'(init_done),  int'(e_done));
      end
   end

   // one series; kill_at < 0 lets it finish (R9), otherwise rst mid-run (R10)
   task automatic run_seq(input int kill_at, input bit noisy);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 1; c < TOTAL + 12; c++) begin
         if (c == kill_at) begin
            start = 1'b0;
            mid = 1'b1; rst = 1'b1;
            @(negedge clk); rst = 1'b0;
            repeat (2) @(negedge clk);
            mid = 1'b0;
            return;
         end
         start = noisy && ($urandom % 16 == 0);   // R9: ignored outside idle
         @(negedge clk);
      end
      start = 1'b0;
      rst = 1'b1;                                  // R1: back to idle
      @(negedge clk); rst = 1'b0;
      repeat ($urandom_range(1, 12)) @(negedge clk);
   endtask

   always @(posedge clk) begin
      if (cycles > 200000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (5) @(negedge clk);                   // R1: idle with no start
      run_seq(-1, 1'b0);                           // R4 R5 R6 R7 clean run
      run_seq(-1, 1'b1);                           // R9 start pulses ignored
      run_seq(1, 1'b0);                            // R10 right after launch
      run_seq(S_CYC + HOLD_RST + 2, 1'b0);         // R10 during clock-enable hold
      run_seq(CMD_BASE + T_RP + 1, 1'b0);          // R10 just after extended write
      run_seq(TOTAL - 1, 1'b0);                    // R10 in the last refresh gap
      for (int r = 0; r < 6; r++) begin
         if ($urandom % 2 == 0) run_seq($urandom_range(1, TOTAL), 1'b1);
         else                   run_seq(-1, 1'b1);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule